// File: doc/BRIEF.md
# Clock-Chip Configuration Sequencer

This block lives inside an FPGA and loads a fixed configuration into an external clock-distribution device over a three-wire serial link: a data line, a serial clock and a latch-enable strobe. A single start pulse launches the whole programming run. The block walks an internal list of 32-bit words and sends each one bit-serially. After the last word it raises a done flag and holds it there.

The list always begins with a device-reset word. The channel words for outputs 0 to 7 come next in ascending order, then a fixed auxiliary word for register 9, and finally the global word for register 14. That last word carries the input-clock select, the global output enable and a power-down bit that must be 0. The device outputs stay dark until it arrives.

A channel word whose divider field (bits 15:8) holds zero is illegal, even in bypass routing. The block therefore rewrites that field to one before sending. A channel entry that is entirely zero counts as unused and is not sent. Every word carries its target register address in bits 3:0. The serial clock comes from the system clock through a parameterised divider, and the default gives roughly 1 MHz from 125 MHz.

Top module: `clkcfg_sequencer`

## Requirements
- R1: While rst_n is low and after reset, ser_clk, ser_le, ser_data, busy and done are all 0.
- R2: A start pulse while idle raises busy on the next clock edge, clears done, and the first word sent is the reset word (default 32'h8000_0000, bit 31 set, address 0).
- R3: Words are sent in this order: reset word, the channel entries for channels 0 to 7 in ascending order, the auxiliary register-9 word, and last the register-14 global word.
- R4: Each word is sent MSB first as exactly 32 ser_clk rising edges. ser_data changes only while ser_clk is low and holds steady while ser_clk is high.
- R5: ser_le stays low while the 32 bits are clocked. It then pulses high for at least one bit period (2*HALF_DIV system clocks) with ser_clk held low.
- R6: Within a word, ser_clk has a period of exactly 2*HALF_DIV system clocks.
- R7: In a channel word a divider field of zero (bits 15:8 == 0) is sent as 1, and every other bit stays unchanged. A nonzero divider field is sent as given.
- R8: A channel entry equal to 32'h0 is skipped and produces no transfer.
- R9: After the last word, busy is 0 and done stays 1, with ser_clk and ser_le idle low, until the next start.
- R10: A start pulse while busy is ignored: the run neither restarts nor repeats any word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a programming run |
| ser_clk | output | 1 | Serial clock to the device |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Latch-enable strobe after each word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished; held until the next start |

## Verification
The assertions watch the line discipline on every cycle. The latch strobe never coincides with a high serial clock, and data never moves during a clock-high phase. busy and done are never high together, a start during a run never moves the word index backwards, and no channel word is loaded with a zero divider field. Only the bench's scenarios can show the full word order, the skipping of empty entries, the exact serial clock period, the latch width, and that a mid-run start produces no extra or repeated transfer. It shows them by collecting every word off the wire and comparing it against an independently built expected list.

// File: rtl/clkcfg_pkg.sv
// Shared types and helpers for the clock-chip configuration sequencer.
// Assumes 32-bit register words with the address in bits 3:0.
package clkcfg_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PICK,
        SQ_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_SHIFT,
        SH_LATCH
    } shift_state_t;

    // Replace an illegal zero divider field (bits 15:8) with one.
    function automatic logic [WORD_W-1:0] fix_divider(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = w;
        if (w[15:8] == 8'd0) r[15:8] = 8'd1;
        return r;
    endfunction
endpackage

// File: rtl/clkcfg_word_src.sv
// Word source: maps a sequence index to the word to send and whether it is present.
// Index 0 = reset word, 1..NUM_CH = channel entries (divider-corrected),
// NUM_CH+1 = auxiliary word, NUM_CH+2 = global word. Purely combinational.
module clkcfg_word_src #(
    parameter int NUM_CH = 8,
    parameter int IDX_W = 4,
    parameter logic [31:0] RST_WORD = 32'h8000_0000,
    parameter logic [31:0] AUX_WORD = 32'h0022_A009,
    parameter logic [31:0] GLOBAL_WORD = 32'h4800_000E,
    parameter logic [NUM_CH*32-1:0] CH_TABLE = '0
) (
    input  logic [IDX_W-1:0] idx,
    output logic [31:0]      word,
    output logic             present
);
    logic [31:0] ch_raw   [NUM_CH];
    logic [31:0] ch_fixed [NUM_CH];

    // Unpack each channel entry and apply the divider correction.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_raw[g]   = CH_TABLE[g*32 +: 32];
        assign ch_fixed[g] = clkcfg_pkg::fix_divider(CH_TABLE[g*32 +: 32]);
    end

    // Select the word for the current index; empty channel entries are not present.
    always_comb begin
        word    = '0;
        present = 1'b0;
        if (idx == '0) begin
            word    = RST_WORD;
            present = 1'b1;
        end else if (idx == IDX_W'(NUM_CH + 1)) begin
            word    = AUX_WORD;
            present = 1'b1;
        end else if (idx == IDX_W'(NUM_CH + 2)) begin
            word    = GLOBAL_WORD;
            present = 1'b1;
        end
        for (int k = 0; k < NUM_CH; k++) begin
            if (idx == IDX_W'(k + 1)) begin
                word    = ch_fixed[k];
                present = |ch_raw[k];
            end
        end
    end
endmodule

// File: rtl/clkcfg_shifter.sv
// Bit-serial shifter with serial clock divider and latch pulse.
// Sends a loaded word MSB first: data is set while ser_clk is low, and each
// half period lasts HALF_DIV system clocks. After the last bit, ser_le is
// high for two half periods with ser_clk low, then word_done pulses once.
// Assumes load is asserted only while idle is high.
module clkcfg_shifter #(
    parameter int HALF_DIV = 63,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_le,
    output logic              word_done,
    output logic              idle
);
    import clkcfg_pkg::*;

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    shift_state_t      state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [WORD_W-1:0] shreg;
    logic              sclk_q;
    logic              le_q;
    logic              lhalf;
    logic              tick;

    assign tick = (cnt == CNT_LAST);

    // Shift, clock generation and latch sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SH_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            shreg     <= '0;
            sclk_q    <= 1'b0;
            le_q      <= 1'b0;
            lhalf     <= 1'b0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (load) begin
                        shreg  <= word;
                        bitn   <= '0;
                        cnt    <= '0;
                        sclk_q <= 1'b0;
                        state  <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    if (tick) begin
                        cnt <= '0;
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (bitn == BIT_LAST) begin
                                state <= SH_LATCH;
                                le_q  <= 1'b1;
                                lhalf <= 1'b0;
                            end else begin
                                shreg <= shreg << 1;
                                bitn  <= bitn + 1'b1;
                            end
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SH_LATCH: begin
                    if (tick) begin
                        cnt <= '0;
                        if (lhalf) begin
                            le_q      <= 1'b0;
                            state     <= SH_IDLE;
                            word_done <= 1'b1;
                        end else begin
                            lhalf <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    assign ser_clk  = sclk_q;
    assign ser_le   = le_q;
    assign ser_data = (state == SH_SHIFT) & shreg[WORD_W-1];
    assign idle     = (state == SH_IDLE);

    // R5
    le_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_le |-> !ser_clk);

    // R4
    data_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
endmodule

// File: rtl/clkcfg_sequencer.sv
// Top: on start, walks the configuration word list (reset, channels,
// auxiliary, global) and sends each present word through the shifter.
// done is held after the last word until the next start; start is ignored while busy.
module clkcfg_sequencer #(
    parameter int HALF_DIV = 63,
    parameter int NUM_CH = 8,
    parameter logic [31:0] RST_WORD = 32'h8000_0000,
    parameter logic [31:0] AUX_WORD = 32'h0022_A009,
    parameter logic [31:0] GLOBAL_WORD = 32'h4800_000E,
    parameter logic [NUM_CH*32-1:0] CH_TABLE = {
        32'h0001_0107, 32'h0001_0106, 32'h0001_0105, 32'h0001_0104,
        32'h0001_0103, 32'h0001_0102, 32'h0001_0101, 32'h0001_0100 }
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ser_clk,
    output logic ser_data,
    output logic ser_le,
    output logic busy,
    output logic done
);
    import clkcfg_pkg::*;

    localparam int NUM_WORDS = NUM_CH + 3;
    localparam int IDX_W = $clog2(NUM_WORDS + 1);
    localparam logic [IDX_W-1:0] END_IDX = IDX_W'(NUM_WORDS);

    seq_state_t        sq;
    logic [IDX_W-1:0]  idx;
    logic [31:0]       cur_word;
    logic              cur_present;
    logic              load;
    logic              word_done;
    logic              sh_idle;

    clkcfg_word_src #(
        .NUM_CH(NUM_CH), .IDX_W(IDX_W), .RST_WORD(RST_WORD),
        .AUX_WORD(AUX_WORD), .GLOBAL_WORD(GLOBAL_WORD), .CH_TABLE(CH_TABLE)
    ) u_src (
        .idx(idx), .word(cur_word), .present(cur_present)
    );

    clkcfg_shifter #(.HALF_DIV(HALF_DIV), .WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .word(cur_word),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .word_done(word_done), .idle(sh_idle)
    );

    assign load = (sq == SQ_PICK) && (idx != END_IDX) && cur_present && sh_idle;
    assign busy = (sq != SQ_IDLE);

    // Sequence through the word list, skipping absent entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq   <= SQ_IDLE;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            case (sq)
                SQ_IDLE: begin
                    if (start) begin
                        done <= 1'b0;
                        idx  <= '0;
                        sq   <= SQ_PICK;
                    end
                end
                SQ_PICK: begin
                    if (idx == END_IDX) begin
                        done <= 1'b1;
                        sq   <= SQ_IDLE;
                    end else if (!cur_present) begin
                        idx <= idx + 1'b1;
                    end else if (sh_idle) begin
                        sq <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (word_done) begin
                        idx <= idx + 1'b1;
                        sq  <= SQ_PICK;
                    end
                end
                default: sq <= SQ_IDLE;
            endcase
        end
    end

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done) && (idx >= $past(idx)));

    // R7
    divider_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && idx >= IDX_W'(1) && idx <= IDX_W'(NUM_CH)) |-> (cur_word[15:8] != 8'd0));

    // R8
    no_empty_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cur_word != 32'h0));
endmodule

// File: tb/clkcfg_sequencer_test.sv
// Scoreboard bench: the driver queues expected words, the monitor decodes the serial line.
module clkcfg_sequencer_test;
    localparam int HALF = 3;
    localparam logic [31:0] T_RST = 32'h8000_0000;
    localparam logic [31:0] T_AUX = 32'h0022_A009;
    localparam logic [31:0] T_GLB = 32'h4800_000E;
    localparam logic [31:0] CH0 = 32'h0001_0000, CH1 = 32'h0003_0101,
                            CH2 = 32'h0003_0002, CH3 = 32'h0003_0803,
                            CH4 = 32'h0001_0004, CH5 = 32'h0000_0000,
                            CH6 = 32'h0003_FF06, CH7 = 32'h0000_0007;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic ser_clk, ser_data, ser_le, busy, done;

    clkcfg_sequencer #(
        .HALF_DIV(HALF), .NUM_CH(8), .RST_WORD(T_RST), .AUX_WORD(T_AUX),
        .GLOBAL_WORD(T_GLB), .CH_TABLE({CH7, CH6, CH5, CH4, CH3, CH2, CH1, CH0})
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ser_clk(ser_clk),
        .ser_data(ser_data), .ser_le(ser_le), .busy(busy), .done(done)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0, words_rx = 0, bitcnt = 0;
    int last_rise = 0, le_start = 0;
    logic [31:0] rx = '0;
    logic [31:0] exp_q[$];
    bit finished = 0;

    always @(negedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected form of a channel entry after the divider correction (R7).
    function automatic logic [31:0] exp_ch(input logic [31:0] w);
        return (w[15:8] == 8'd0) ? {w[31:16], 8'd1, w[7:0]} : w;
    endfunction

    // Driver: queue the expected words for one run; empty entries are skipped (R8).
    task automatic push_run();
        logic [31:0] chs [8] = '{CH0, CH1, CH2, CH3, CH4, CH5, CH6, CH7};
        exp_q.push_back(T_RST);
        for (int i = 0; i < 8; i++)
            if (chs[i] != 32'h0) exp_q.push_back(exp_ch(chs[i]));
        exp_q.push_back(T_AUX);
        exp_q.push_back(T_GLB);
    endtask

    // Monitor: capture bits on serial clock rising edges, check the period (R6).
    always @(posedge ser_clk) begin
        if (bitcnt > 0) check(cyc - last_rise == 2*HALF, "R6", cyc - last_rise, 2*HALF);
        rx = {rx[30:0], ser_data};
        bitcnt++;
        last_rise = cyc;
    end

    // Monitor: on the latch strobe, compare the captured word with the scoreboard.
    always @(posedge ser_le) begin
        check(ser_clk == 1'b0, "R5", ser_clk, 0);
        check(bitcnt == 32, "R4", bitcnt, 32);
        if (exp_q.size() == 0) begin
            check(1'b0, "R10", rx, 0);
        end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check(rx == e, "R3/R7/R8", rx, e);
        end
        words_rx++;
        bitcnt = 0;
        le_start = cyc;
    end

    always @(negedge ser_le) check(cyc - le_start >= 2*HALF, "R5", cyc - le_start, 2*HALF);

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic finish_run(input string tag);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        check(words_rx == 10, "R8", words_rx, 10);
        repeat (40) @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R9", {done, busy}, 2'b10);
        check(ser_clk == 1'b0 && ser_le == 1'b0, "R9", {ser_clk, ser_le}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ser_clk == 0, "R1", ser_clk, 0);
        check(ser_le == 0, "R1", ser_le, 0);
        check(ser_data == 0, "R1", ser_data, 0);
        check(busy == 0 && done == 0, "R1", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 0 && done == 0, "R1", {busy, done}, 0);

        // Run 1: plain sequence (R2, R3, R7)
        push_run();
        pulse_start();
        check(busy == 1 && done == 0, "R2", {busy, done}, 2'b10);
        wait_done();
        finish_run("R3");

        // Run 2: extra starts mid-run must be ignored (R10); done clears on start (R2)
        words_rx = 0;
        push_run();
        pulse_start();
        check(done == 0 && busy == 1, "R2", {busy, done}, 2'b10);
        repeat (300) @(negedge clk);
        pulse_start();
        repeat (700) @(negedge clk);
        pulse_start();
        wait_done();
        finish_run("R10");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule